// File: doc/BRIEF.md
# Parallel NOR Flash Command Decoder

This block is the write-side command sequencer of a parallel NOR flash device that uses the two-cycle unlock protocol. Every bus write carries a byte address and a command or data byte. The block follows the host through unlock pairs and command cycles. It reports a mode that the read path uses to pick between array data, identification data and the query table. It also hands single-cycle program and erase requests to a separate execution block, which pulses `exec_done` when the operation has finished.

Writes arrive as `wr_valid` beats and no ready signal exists. Every beat is consumed in the cycle it is presented, so the block never applies back-pressure. While an operation is running, beats are still consumed but have no effect. The two unlock word offsets and the bus width are static configuration inputs. They are only changed while no command sequence is open.

Top module: `nor_cmd_decoder`

## Requirements
- R1: Unlock and query addresses are compared as word offsets within a sector. The offset is the byte address modulo the sector size, shifted right by 0, 1 or 2 bits for `width_sel` = 0 (8-bit), 1 (16-bit) or 2 (32-bit).
- R2: An unlock pair is 0xAA written to unlock offset 0, followed by 0x55 written to unlock offset 1. If either beat mismatches in address or data, the block returns to read state with mode READ.
- R3: The beat after an unlock pair must address unlock offset 0 (this check is waived in bypass). It accepts 0xA0 (program), 0x90 (autoselect), 0x80 (erase setup) or 0x20 (enter bypass). Any other value or address resets the block to read state.
- R4: A 0xF0 data byte resets the block to read state and clears bypass, in every state except the program-data beat and the busy state. In the program-data beat, 0xF0 is programmed as data.
- R5: Writing 0x98 to word offset 0x55 enters query mode, from read state and from autoselect mode. Any write in query mode returns the block to read state. Mode encodings: READ=0, AUTOSELECT=1, CFI=2, BUSY=3.
- R6: In bypass, a command beat needs no unlock pair and may use any address. When a program completes, the block returns to the command beat, not to read state.
- R7: In bypass, autoselect followed by a 0x00 write leaves bypass and returns the block to read state.
- R8: Erase setup needs a second unlock pair. After it, 0x10 at unlock offset 0 requests a chip erase (`erase_chip`=1, base 0). 0x10 at any other offset resets the block. 0x30 at any address requests a sector erase, with the base equal to the address with its low SECT_W bits cleared.
- R9: The program-data beat produces a one-cycle `prog_req` in the cycle after that beat, carrying the beat's byte address and data.
- R10: After a program or erase request, mode is BUSY and all writes are ignored until `exec_done`. The block then goes to the command beat if bypass is active, and to read state otherwise.
- R11: After reset, mode is READ, no request is raised and bypass is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| width_sel | input | 2 | Bus width: 0=8, 1=16, 2=32 bit |
| unlock_addr0 | input | SECT_W | First unlock word offset |
| unlock_addr1 | input | SECT_W | Second unlock word offset |
| wr_valid | input | 1 | Write beat present (always consumed) |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 8 | Command or data byte |
| exec_done | input | 1 | Running operation has finished |
| mode | output | 2 | READ / AUTOSELECT / CFI / BUSY |
| prog_req | output | 1 | One-cycle program request |
| prog_addr | output | ADDR_W | Program byte address |
| prog_data | output | 8 | Program data byte |
| erase_req | output | 1 | One-cycle erase request |
| erase_chip | output | 1 | 1 = chip erase, 0 = sector erase |
| erase_base | output | ADDR_W | Erase base address |

## Verification
The decoder is driven with these sequences:
- Complete program and erase sequences.
- Sequences broken at each beat by a wrong address or a wrong data byte.
- 0xF0 injected both mid-sequence and as program data.
- Query entry from read state and from autoselect mode.

The broken sequences separate the address checks from the data checks. The 0xF0 cases separate the global reset from the data path. Bypass runs with arbitrary command addresses show that the address waiver and the return to the command beat work. Repeating the unlock sequence at 16- and 32-bit widths, including byte addresses that only match without scaling, shows that the word-offset shift is applied.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;
  typedef enum logic [1:0] {
    MODE_READ    = 2'd0,
    MODE_AUTOSEL = 2'd1,
    MODE_CFI     = 2'd2,
    MODE_BUSY    = 2'd3
  } nor_mode_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_UNLOCK2, ST_COMMAND, ST_PROG_DATA, ST_AUTOSEL,
    ST_ERASE_U1, ST_ERASE_U2, ST_ERASE_FINAL, ST_QUERY, ST_BUSY
  } nor_state_e;

  localparam logic [7:0] CODE_UNLOCK_A = 8'hAA;
  localparam logic [7:0] CODE_UNLOCK_B = 8'h55;
  localparam logic [7:0] CODE_PROGRAM  = 8'hA0;
  localparam logic [7:0] CODE_AUTOSEL  = 8'h90;
  localparam logic [7:0] CODE_ERASE    = 8'h80;
  localparam logic [7:0] CODE_BYPASS   = 8'h20;
  localparam logic [7:0] CODE_CHIP     = 8'h10;
  localparam logic [7:0] CODE_SECTOR   = 8'h30;
  localparam logic [7:0] CODE_QUERY    = 8'h98;
  localparam logic [7:0] CODE_RESET    = 8'hF0;
  localparam logic [7:0] CODE_BYP_EXIT = 8'h00;
  localparam int unsigned QUERY_OFFSET = 32'h55;

  function automatic nor_mode_e mode_of(nor_state_e s);
    case (s)
      ST_AUTOSEL: return MODE_AUTOSEL;
      ST_QUERY:   return MODE_CFI;
      ST_BUSY:    return MODE_BUSY;
      default:    return MODE_READ;
    endcase
  endfunction
endpackage

// File: rtl/nor_word_offset.sv
module nor_word_offset #(
  parameter int ADDR_W = 20,
  parameter int SECT_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        width_sel,
  output logic [SECT_W-1:0] woff
);
  logic [SECT_W-1:0] in_sector;
  assign in_sector = addr[SECT_W-1:0];

  always_comb begin
    case (width_sel)
      2'd1:    woff = {1'b0,  in_sector[SECT_W-1:1]};
      2'd2:    woff = {2'b00, in_sector[SECT_W-1:2]};
      default: woff = in_sector;
    endcase
  end
endmodule

// File: rtl/nor_cmd_fsm.sv
module nor_cmd_fsm
  import nor_cmd_pkg::*;
#(
  parameter int SECT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [7:0]        wr_data,
  input  logic [SECT_W-1:0] woff,
  input  logic [SECT_W-1:0] ua0,
  input  logic [SECT_W-1:0] ua1,
  input  logic              exec_done,
  output nor_state_e        state,
  output logic              bypass,
  output logic              fire_prog,
  output logic              fire_chip,
  output logic              fire_sector
);
  localparam logic [SECT_W-1:0] QOFF = SECT_W'(QUERY_OFFSET);

  nor_state_e nxt;
  logic       nxt_bypass;
  logic       at_ua0, at_ua1, query_hit, unlock_a_hit;

  assign at_ua0       = (woff == ua0);
  assign at_ua1       = (woff == ua1);
  assign query_hit    = (woff == QOFF) && (wr_data == CODE_QUERY);
  assign unlock_a_hit = at_ua0 && (wr_data == CODE_UNLOCK_A);

  always_comb begin
    nxt         = state;
    nxt_bypass  = bypass;
    fire_prog   = 1'b0;
    fire_chip   = 1'b0;
    fire_sector = 1'b0;
    if (state == ST_BUSY) begin
      if (exec_done) nxt = bypass ? ST_COMMAND : ST_IDLE;
    end else if (wr_valid) begin
      nxt        = ST_IDLE;
      nxt_bypass = 1'b0;
      if (wr_data == CODE_RESET && state != ST_PROG_DATA) begin
        nxt = ST_IDLE;
      end else begin
        case (state)
          ST_IDLE:
            if (query_hit)         nxt = ST_QUERY;
            else if (unlock_a_hit) nxt = ST_UNLOCK2;
          ST_UNLOCK2:
            if (at_ua1 && wr_data == CODE_UNLOCK_B) nxt = ST_COMMAND;
          ST_COMMAND:
            if (bypass || at_ua0) begin
              nxt_bypass = bypass;
              case (wr_data)
                CODE_BYPASS:  begin nxt = ST_COMMAND; nxt_bypass = 1'b1; end
                CODE_PROGRAM: nxt = ST_PROG_DATA;
                CODE_AUTOSEL: nxt = ST_AUTOSEL;
                CODE_ERASE:   nxt = ST_ERASE_U1;
                default:      begin nxt = ST_IDLE; nxt_bypass = 1'b0; end
              endcase
            end
          ST_PROG_DATA: begin
            fire_prog  = 1'b1;
            nxt        = ST_BUSY;
            nxt_bypass = bypass;
          end
          ST_AUTOSEL:
            if (!(bypass && wr_data == CODE_BYP_EXIT) && query_hit) begin
              nxt = ST_QUERY;
            end
          ST_ERASE_U1:
            if (unlock_a_hit) begin nxt = ST_ERASE_U2; nxt_bypass = bypass; end
          ST_ERASE_U2:
            if (at_ua1 && wr_data == CODE_UNLOCK_B) begin
              nxt = ST_ERASE_FINAL; nxt_bypass = bypass;
            end
          ST_ERASE_FINAL:
            if (wr_data == CODE_CHIP && at_ua0) begin
              fire_chip = 1'b1; nxt = ST_BUSY; nxt_bypass = bypass;
            end else if (wr_data == CODE_SECTOR) begin
              fire_sector = 1'b1; nxt = ST_BUSY; nxt_bypass = bypass;
            end
          default: nxt = ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      bypass <= 1'b0;
    end else begin
      state  <= nxt;
      bypass <= nxt_bypass;
    end
  end

  // R10: a running operation only ends on exec_done
  p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BUSY && !exec_done) |=> state == ST_BUSY);
  // R5: any write while in query mode leaves it for read state
  p_query_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_QUERY && wr_valid) |=> state == ST_IDLE);
  // R6: bypass is only ever entered at the command beat
  p_bypass_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bypass) |-> state == ST_COMMAND);
endmodule

// File: rtl/nor_req_regs.sv
module nor_req_regs #(
  parameter int ADDR_W = 20,
  parameter int SECT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire_prog,
  input  logic              fire_chip,
  input  logic              fire_sector,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        data,
  output logic              prog_req,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [7:0]        prog_data,
  output logic              erase_req,
  output logic              erase_chip,
  output logic [ADDR_W-1:0] erase_base
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prog_req   <= 1'b0;
      prog_addr  <= '0;
      prog_data  <= '0;
      erase_req  <= 1'b0;
      erase_chip <= 1'b0;
      erase_base <= '0;
    end else begin
      prog_req  <= fire_prog;
      erase_req <= fire_chip || fire_sector;
      if (fire_prog) begin
        prog_addr <= addr;
        prog_data <= data;
      end
      if (fire_chip) begin
        erase_chip <= 1'b1;
        erase_base <= '0;
      end else if (fire_sector) begin
        erase_chip <= 1'b0;
        erase_base <= {addr[ADDR_W-1:SECT_W], {SECT_W{1'b0}}};
      end
    end
  end

  // R9: a program request lasts a single cycle
  p_prog_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |=> !prog_req);
  // R10: program and erase never requested together
  p_req_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(prog_req && erase_req));
endmodule

// File: rtl/nor_cmd_decoder.sv
module nor_cmd_decoder
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int SECT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        width_sel,
  input  logic [SECT_W-1:0] unlock_addr0,
  input  logic [SECT_W-1:0] unlock_addr1,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              exec_done,
  output logic [1:0]        mode,
  output logic              prog_req,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [7:0]        prog_data,
  output logic              erase_req,
  output logic              erase_chip,
  output logic [ADDR_W-1:0] erase_base
);
  logic [SECT_W-1:0] woff;
  nor_state_e        state;
  logic              bypass, fire_prog, fire_chip, fire_sector;

  nor_word_offset #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_woff (
    .addr(wr_addr), .width_sel(width_sel), .woff(woff));

  nor_cmd_fsm #(.SECT_W(SECT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .woff(woff), .ua0(unlock_addr0), .ua1(unlock_addr1),
    .exec_done(exec_done), .state(state), .bypass(bypass),
    .fire_prog(fire_prog), .fire_chip(fire_chip), .fire_sector(fire_sector));

  nor_req_regs #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_req (
    .clk(clk), .rst_n(rst_n), .fire_prog(fire_prog), .fire_chip(fire_chip),
    .fire_sector(fire_sector), .addr(wr_addr), .data(wr_data),
    .prog_req(prog_req), .prog_addr(prog_addr), .prog_data(prog_data),
    .erase_req(erase_req), .erase_chip(erase_chip), .erase_base(erase_base));

  assign mode = mode_of(state);

  // R10: every request is accompanied by the BUSY mode
  p_req_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_req || erase_req) |-> mode == MODE_BUSY);
  // R11: leaving reset the block sits in read mode with no request
  p_reset_state_r11: assert property (@(posedge clk)
    !rst_n |=> (mode == MODE_READ && !prog_req && !erase_req));
endmodule

// File: tb/test_nor_cmd_decoder.sv
`timescale 1ns/1ps
module test_nor_cmd_decoder;
  localparam int AW = 20;
  localparam int SW = 16;
  localparam int UA0 = 'h555;
  localparam int UA1 = 'h2AA;

  logic clk = 0, rst_n = 0;
  logic [1:0] width_sel = 0;
  logic wr_valid = 0, exec_done = 0;
  logic [AW-1:0] wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic [1:0] mode;
  logic prog_req, erase_req, erase_chip;
  logic [AW-1:0] prog_addr, erase_base;
  logic [7:0] prog_data;

  always #4 clk = ~clk;

  nor_cmd_decoder #(.ADDR_W(AW), .SECT_W(SW)) i_nor_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .width_sel(width_sel),
    .unlock_addr0(SW'(UA0)), .unlock_addr1(SW'(UA1)),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .exec_done(exec_done), .mode(mode), .prog_req(prog_req),
    .prog_addr(prog_addr), .prog_data(prog_data), .erase_req(erase_req),
    .erase_chip(erase_chip), .erase_base(erase_base));

  int n_cmp = 0, n_bad = 0, sh = 0;
  string cur_req = "R11";
  // reference model: phase names are plain text
  string ph = "read";
  bit byp = 0;
  int e_mode = 0, e_paddr = 0, e_pdata = 0, e_ebase = 0;
  bit e_preq = 0, e_ereq = 0, e_echip = 0;

  function automatic int wofs(int a);
    return (a % (1 << SW)) >> sh;
  endfunction

  task automatic go_read();
    ph = "read"; byp = 0;
  endtask

  task automatic model(bit v, int a, int d, bit dn);
    int w = wofs(a);
    e_preq = 0; e_ereq = 0;
    if (ph == "busy") begin
      if (dn) ph = byp ? "cmd" : "read";
    end else if (v) begin
      if (d == 'hF0 && ph != "pdata") go_read();
      else if (ph == "read") begin
        if (w == 'h55 && d == 'h98) ph = "cfi";
        else if (w == UA0 && d == 'hAA) ph = "u2";
        else go_read();
      end else if (ph == "u2") begin
        if (w == UA1 && d == 'h55) ph = "cmd"; else go_read();
      end else if (ph == "cmd") begin
        if (!byp && w != UA0) go_read();
        else if (d == 'h20) byp = 1;
        else if (d == 'hA0) ph = "pdata";
        else if (d == 'h90) ph = "auto";
        else if (d == 'h80) ph = "e1";
        else go_read();
      end else if (ph == "pdata") begin
        e_preq = 1; e_paddr = a; e_pdata = d; ph = "busy";
      end else if (ph == "auto") begin
        if (!(byp && d == 0) && w == 'h55 && d == 'h98) begin ph = "cfi"; byp = 0; end
        else go_read();
      end else if (ph == "e1") begin
        if (w == UA0 && d == 'hAA) ph = "e2"; else go_read();
      end else if (ph == "e2") begin
        if (w == UA1 && d == 'h55) ph = "efin"; else go_read();
      end else if (ph == "efin") begin
        if (d == 'h10 && w == UA0) begin e_ereq = 1; e_echip = 1; e_ebase = 0; ph = "busy"; end
        else if (d == 'h30) begin
          e_ereq = 1; e_echip = 0; e_ebase = a & ~((1 << SW) - 1); ph = "busy";
        end else go_read();
      end else go_read();
    end
    e_mode = (ph == "auto") ? 1 : (ph == "cfi") ? 2 : (ph == "busy") ? 3 : 0;
  endtask

  task automatic compare();
    bit bad;
    n_cmp++;
    bad = (mode != 2'(e_mode)) || (prog_req != e_preq) || (erase_req != e_ereq);
    if (e_preq && (prog_addr != AW'(e_paddr) || prog_data != 8'(e_pdata))) bad = 1;
    if (e_ereq && (erase_chip != e_echip || erase_base != AW'(e_ebase))) bad = 1;
    if (bad) begin
      n_bad++;
      $display("FAIL %s: mode=%0d preq=%0b paddr=%h pdata=%h ereq=%0b chip=%0b base=%h | exp mode=%0d preq=%0b paddr=%h pdata=%h ereq=%0b chip=%0b base=%h",
        cur_req, mode, prog_req, prog_addr, prog_data, erase_req, erase_chip, erase_base,
        e_mode, e_preq, e_paddr, e_pdata, e_ereq, e_echip, e_ebase);
    end
  endtask

  task automatic cyc(bit v, int a, int d, bit dn);
    @(negedge clk);
    compare();
    wr_valid = v; wr_addr = AW'(a); wr_data = 8'(d); exec_done = dn;
    model(v, a, d, dn);
  endtask

  task automatic wr(int a, int d); cyc(1, a, d, 0); endtask
  task automatic idle(); cyc(0, 0, 0, 0); endtask
  task automatic done(); cyc(0, 0, 0, 1); endtask
  task automatic unlock(); wr(UA0 << sh, 'hAA); wr(UA1 << sh, 'h55); endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: run did not end, expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    cur_req = "R11"; idle(); idle();
    // R2 R3 R9 R10: full program, writes ignored while busy
    cur_req = "R9"; unlock(); wr(UA0, 'hA0); wr('h12345, 'h3C);
    cur_req = "R10"; wr(UA0, 'hAA); wr(UA0, 'hF0); idle(); done(); idle();
    // R2: broken unlock pairs
    cur_req = "R2"; wr(UA0, 'hAA); wr('h100, 'h55); wr(UA0, 'hA0); wr('h40, 'h11);
    wr(UA0, 'hAB); wr(UA1, 'h55); wr(UA0, 'hA0); idle();
    // R3: bad command address and bad code
    cur_req = "R3"; unlock(); wr('h123, 'hA0); wr('h40, 'h22);
    unlock(); wr(UA0, 'h77); wr('h40, 'h22); idle();
    // R4: F0 mid-sequence, F0 as program data
    cur_req = "R4"; wr(UA0, 'hAA); wr(UA1, 'hF0); wr(UA0, 'h90); idle();
    unlock(); wr(UA0, 'hA0); wr('h7777, 'hF0); done(); idle();
    unlock(); wr(UA0, 'h90); wr('h0, 'hF0); idle();
    // R5: query from read and from autoselect
    cur_req = "R5"; wr('h55, 'h98); idle(); wr('h0, 'h12); idle();
    unlock(); wr(UA0, 'h90); wr('h55, 'h98); idle(); wr('h55, 'h98); idle();
    // R8: erase flows
    cur_req = "R8"; unlock(); wr(UA0, 'h80); unlock(); wr(UA0, 'h10); done();
    unlock(); wr(UA0, 'h80); unlock(); wr('h3ABCD, 'h30); idle(); done();
    unlock(); wr(UA0, 'h80); unlock(); wr('h100, 'h10); wr('h40, 'h30); idle();
    unlock(); wr(UA0, 'h80); wr(UA1, 'hAA); idle();
    // R6: bypass programs
    cur_req = "R6"; unlock(); wr(UA0, 'h20); wr('h999, 'hA0); wr('h2468, 'h5A); done();
    wr('h1, 'hA0); wr('h1357, 'hC3); done(); idle();
    // R7: leave bypass through autoselect + 0x00
    cur_req = "R7"; wr('h3, 'h90); wr('h3, 'h00); wr('h9, 'hA0); wr('h9, 'h01); idle();
    unlock(); wr(UA0, 'h20); wr('h0, 'h90); wr('h55, 'h98); idle(); wr('h0, 'hF0); idle();
    // R1: 16- and 32-bit widths
    cur_req = "R1"; sh = 1; width_sel = 1; idle();
    unlock(); wr(UA0 << 1, 'hA0); wr('h8000, 'h0F); done();
    wr(UA0, 'hAA); wr(UA1, 'h55); wr(UA0, 'h90); idle(); wr('hAA, 'h98); idle(); wr(0, 0);
    sh = 2; width_sel = 2; idle();
    unlock(); wr(UA0 << 2, 'h90); wr('h154, 'h98); idle(); wr(0, 0);
    wr(UA0 << 1, 'hAA); idle();
    @(negedge clk); compare();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule